// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialization

This block decides when a dynamic memory must be refreshed and hands each refresh to a memory cycle sequencer. After reset it first waits out a mandatory power-up pause. It then issues a warm-up burst of refreshes. Only after that does it switch to periodic refresh. In the periodic phase, a free-running interval timer adds one owed refresh every interval. The interval is derived from the clock period so that 1024 rows are covered within the 16 ms retention window, which gives at most 15.6 µs per row.

Each request presents a 10-bit row address taken from an internal counter, so the sequencer can run a row-addressed (strobe-only) refresh. A sequencer that prefers the memory's own internal row counter can ignore the address and use the request alone to start a column-strobe-first refresh.

The request side is a valid/ready pair. `refresh_req` plays the role of valid and `refresh_ack` plays the role of ready. A transfer happens on a rising edge where both are high. While a request is pending and no acknowledge arrives, the request stays high and the address stays unchanged. The sequencer may hold `refresh_ack` high indefinitely. It has no effect while no request is pending.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and just after it, `refresh_req`, `init_done` and `backlog_overflow` are 0 and `row_addr` is 0.
- R2: `refresh_req` stays 0 for the first PAUSE_CYCLES-1 rising edges after reset release and is 1 after edge PAUSE_CYCLES.
- R3: During warm-up, `refresh_req` stays 1 whether or not it is acknowledged. `init_done` stays 0 until the edge of the WARMUP_COUNT-th transfer, is 1 from that edge on, and never falls before the next reset.
- R4: `row_addr` increments by one on every transfer (`refresh_req` and `refresh_ack` both 1 at a rising edge), is unchanged otherwise, and wraps from 1023 to 0.
- R5: After `init_done` rises, one refresh becomes owed every INTERVAL_CYCLES edges. The first is owed on the INTERVAL_CYCLES-th edge after the edge on which `init_done` rose.
- R6: An owed refresh that is not acknowledged keeps `refresh_req` at 1.
- R7: Up to BACKLOG_MAX owed refreshes are kept without loss. Draining them with a continuously high acknowledge yields exactly that many transfers before `refresh_req` falls.
- R8: An interval expiring while BACKLOG_MAX refreshes are already owed, with no transfer on that edge, sets `backlog_overflow`. The flag stays set until reset.
- R9: With the acknowledge held high in the periodic phase, `refresh_req` is high in one cycle out of every INTERVAL_CYCLES. Consecutive high cycles are exactly INTERVAL_CYCLES edges apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_ack | input | 1 | Sequencer accepts the current refresh (ready) |
| refresh_req | output | 1 | A refresh is wanted (valid) |
| row_addr | output | ROW_BITS | Row to refresh for a row-addressed refresh |
| init_done | output | 1 | Pause and warm-up refreshes have completed |
| backlog_overflow | output | 1 | Sticky: an owed refresh was lost |

## Verification
The bench counts edges exactly across the pause-to-warm-up and warm-up-to-periodic boundaries. A design with an off-by-one pause or warm-up count would raise the request, or `init_done`, one cycle early or late. It lets the backlog fill to its limit and then one interval more. This exposes a design that wraps or saturates the owed count silently, or that raises the flag one refresh too soon. In that case the drain would yield the wrong number of transfers, or the flag would appear at the wrong tick. A sweep of more than 1024 periodic refreshes checks the spacing of every request and the address after each transfer, which catches a bad interval reload and an address that fails to wrap at 1023.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE  = 2'd0,
    PH_WARMUP = 2'd1,
    PH_RUN    = 2'd2
  } ref_phase_t;

  // rounds a duration up to whole clock cycles
  function automatic int ns_to_cycles_ceil(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  // rounds a duration down so a period never exceeds the bound
  function automatic int ns_to_cycles_floor(input int ns, input int period_ns);
    return ns / period_ns;
  endfunction
endpackage

// File: rtl/rf_init_seq.sv
module rf_init_seq
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYCLES = 5000,
  parameter int WARMUP_COUNT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer,
  output ref_phase_t phase
);
  localparam int PW = $clog2(PAUSE_CYCLES + 1);
  localparam int WW = $clog2(WARMUP_COUNT + 1);

  logic [PW-1:0] pause_cnt;
  logic [WW-1:0] warm_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_PAUSE;
      pause_cnt <= '0;
      warm_cnt  <= '0;
    end else begin
      unique case (phase)
        PH_PAUSE: begin
          if (pause_cnt == PW'(PAUSE_CYCLES - 1)) phase <= PH_WARMUP;
          else pause_cnt <= pause_cnt + 1'b1;
        end
        PH_WARMUP: begin
          if (xfer) begin
            if (warm_cnt == WW'(WARMUP_COUNT - 1)) phase <= PH_RUN;
            else warm_cnt <= warm_cnt + 1'b1;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  // R2: the pause never jumps straight to the periodic phase
  pause_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE) |=> (phase != PH_RUN));

  // R3: once periodic, the sequencer stays periodic until reset
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (phase == PH_RUN));
endmodule

// File: rtl/rf_interval_timer.sv
module rf_interval_timer #(
  parameter int INTERVAL_CYCLES = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int IW = $clog2(INTERVAL_CYCLES + 1);

  logic [IW-1:0] icnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      icnt <= '0;
    end else if (icnt == IW'(INTERVAL_CYCLES - 1)) begin
      icnt <= '0;
    end else begin
      icnt <= icnt + 1'b1;
    end
  end

  assign tick = enable && (icnt == IW'(INTERVAL_CYCLES - 1));

  generate
    if (INTERVAL_CYCLES > 1) begin : g_spacing
      // R5: interval expiries are never back to back
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/rf_backlog.sv
module rf_backlog #(
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic take,
  output logic pending,
  output logic overflow
);
  localparam int OW = $clog2(BACKLOG_MAX + 1);

  logic [OW-1:0] owed;
  logic          full;

  assign full    = (owed == OW'(BACKLOG_MAX));
  assign pending = (owed != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed     <= '0;
      overflow <= 1'b0;
    end else begin
      unique case ({add, take && pending})
        2'b10: begin
          if (full) overflow <= 1'b1;
          else owed <= owed + 1'b1;
        end
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  // R7: the owed count never passes its limit
  owed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(BACKLOG_MAX));

  // R6: an unaccepted owed refresh is not dropped
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> pending);

  // R8: the loss flag is sticky
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_PERIOD_NS   = 20,
  parameter int ROW_BITS        = 10,
  parameter int INTERVAL_CYCLES = ns_to_cycles_floor(15600, CLK_PERIOD_NS),
  parameter int PAUSE_CYCLES    = ns_to_cycles_ceil(100000, CLK_PERIOD_NS),
  parameter int WARMUP_COUNT    = 8,
  parameter int BACKLOG_MAX     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refresh_ack,
  output logic                refresh_req,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                init_done,
  output logic                backlog_overflow
);
  ref_phase_t phase;
  logic       in_run;
  logic       tick;
  logic       pending;
  logic       xfer;

  assign in_run      = (phase == PH_RUN);
  assign refresh_req = (phase == PH_WARMUP) || (in_run && pending);
  assign xfer        = refresh_req && refresh_ack;
  assign init_done   = in_run;

  rf_init_seq #(
    .PAUSE_CYCLES (PAUSE_CYCLES),
    .WARMUP_COUNT (WARMUP_COUNT)
  ) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .xfer  (xfer),
    .phase (phase)
  );

  rf_interval_timer #(
    .INTERVAL_CYCLES (INTERVAL_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (in_run),
    .tick   (tick)
  );

  rf_backlog #(
    .BACKLOG_MAX (BACKLOG_MAX)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .add      (tick),
    .take     (xfer && in_run),
    .pending  (pending),
    .overflow (backlog_overflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) row_addr <= '0;
    else if (xfer) row_addr <= row_addr + 1'b1;
  end

  // R4: each transfer moves to the next row, modulo the row count
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && refresh_ack) |=> (row_addr == $past(row_addr) + 1'b1));

  // R4: without a transfer the row holds
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(refresh_req && refresh_ack) |=> $stable(row_addr));

  // R3: completion never falls back
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R6: a request waits for its acknowledge
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);
endmodule

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
  localparam int ROWS  = 10;
  localparam int IVL   = 12;
  localparam int PAUSE = 40;
  localparam int WARM  = 8;
  localparam int BMAX  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            refresh_ack = 1'b0;
  logic            refresh_req;
  logic [ROWS-1:0] row_addr;
  logic            init_done;
  logic            backlog_overflow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .CLK_PERIOD_NS   (20),
    .ROW_BITS        (ROWS),
    .INTERVAL_CYCLES (IVL),
    .PAUSE_CYCLES    (PAUSE),
    .WARMUP_COUNT    (WARM),
    .BACKLOG_MAX     (BMAX)
  ) uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .refresh_ack      (refresh_ack),
    .refresh_req      (refresh_req),
    .row_addr         (row_addr),
    .init_done        (init_done),
    .backlog_overflow (backlog_overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 req", int'(refresh_req), 0);
    check("R1 row", int'(row_addr), 0);
    check("R1 init_done", int'(init_done), 0);
    check("R1 overflow", int'(backlog_overflow), 0);
    rst_n = 1'b1;

    // R2: pause length
    for (int k = 1; k < PAUSE; k++) begin
      @(negedge clk);
      check("R2 req during pause", int'(refresh_req), 0);
    end
    @(negedge clk);
    check("R2 req after pause", int'(refresh_req), 1);
    check("R3 init_done at warmup start", int'(init_done), 0);

    // R3/R6: warm-up request is held without acknowledge
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R3 warmup req held", int'(refresh_req), 1);
      check("R4 row idle", int'(row_addr), 0);
    end

    // R3/R4: warm-up transfers
    for (int a = 1; a <= WARM; a++) begin
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
      check("R4 row after warmup xfer", int'(row_addr), a);
      check("R3 init_done", int'(init_done), (a == WARM) ? 1 : 0);
    end
    check("R5 no req right after init", int'(refresh_req), 0);

    // R5: first interval
    for (int j = 1; j < IVL; j++) begin
      @(negedge clk);
      check("R5 req before interval", int'(refresh_req), 0);
    end
    @(negedge clk);
    check("R5 req at interval", int'(refresh_req), 1);

    // R6/R7: backlog fills to its limit
    repeat (3 * IVL) @(negedge clk);
    check("R6 req held while owed", int'(refresh_req), 1);
    check("R8 no overflow at limit", int'(backlog_overflow), 0);
    for (int j = 1; j < IVL; j++) begin
      @(negedge clk);
      check("R8 no overflow before extra tick", int'(backlog_overflow), 0);
    end
    @(negedge clk);
    check("R8 overflow on extra tick", int'(backlog_overflow), 1);
    check("R4 row held without ack", int'(row_addr), WARM);

    // R7: drain yields exactly BMAX transfers
    refresh_ack = 1'b1;
    for (int k = 1; k <= BMAX; k++) begin
      @(negedge clk);
      check("R7 row during drain", int'(row_addr), WARM + k);
      check("R7 req during drain", int'(refresh_req), (k < BMAX) ? 1 : 0);
    end
    check("R8 overflow sticky", int'(backlog_overflow), 1);

    // R9/R4: long sweep with acknowledge held, across the row wrap
    g = 0;
    for (int n = 1; n <= 1030; n++) begin
      while (!refresh_req && g < 4 * IVL) begin
        @(negedge clk);
        g++;
      end
      if (n > 1) check("R9 request spacing", g, IVL);
      @(negedge clk);
      check("R4 row in sweep", int'(row_addr), (WARM + BMAX + n) % (1 << ROWS));
      g = 1;
    end
    check("R8 overflow still set", int'(backlog_overflow), 1);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    refresh_ack = 1'b0;
    @(negedge clk);
    check("R1 row after reset", int'(row_addr), 0);
    check("R1 overflow after reset", int'(backlog_overflow), 0);
    check("R1 init_done after reset", int'(init_done), 0);
    check("R1 req after reset", int'(refresh_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule